// File: doc/BRIEF.md
# LED Brightness PWM Setup Controller

This block turns a brightness request into the settings that a separate PWM counter channel uses. Configuration inputs give the rate of the source clock, the largest brightness code, and the wanted refresh rate. A refresh rate of zero selects 100. When a brightness value arrives with its strobe, the controller stops the channel and chooses a clock prescaler. It then derives the period and the compare point with a shared sequential divider, and only after both are loaded does it enable the channel again.

The two extreme brightness codes do not use PWM. At brightness zero, and at brightness equal to the configured maximum, the pin is switched to a plain static output. That output is driven low for zero and high for maximum. Every other code routes the pin to the timer function.

A request that arrives while a setup is still running is held in a one-entry slot. Each later request overwrites the slot, so only the newest one is processed once the current setup ends. The configuration inputs are expected to stay stable while `busy_o` is high.

Top module: `led_pwm_setup`

## Requirements
- R1: After reset the PWM enable is 0, the pin is selected as static (pin_static_o=1) at level 0, the error flag is 0, and the block is not busy.
- R2: The minimum count rate is max_bri_i times the effective refresh rate. The prescaler is the largest divider of 64, 16, 4, 1 for which floor(src_rate_i / divider) is at least that minimum. psc_code_o encodes the divider as 3, 2, 1, 0 respectively, so that divider = 4^code.
- R3: For an intermediate brightness where no divider meets the minimum, the error flag goes to 1, PWM stays disabled, and the pin is routed to the timer function (pin_static_o=0).
- R4: period_o equals floor(src_rate_i / (divider * effective refresh rate)).
- R5: compare_o equals floor((max_bri_i - brightness) * period_o / max_bri_i).
- R6: Brightness 0 gives pin_static_o=1 with pin_level_o=0. Brightness equal to max_bri_i gives pin_static_o=1 with pin_level_o=1. In both cases pwm_en_o is 0.
- R7: Any other brightness with a fitting prescaler ends with pin_static_o=0 and pwm_en_o=1.
- R8: pwm_en_o is 0 for the whole time busy_o is 1. The channel is stopped first and re-enabled only after period and compare are loaded.
- R9: A refresh_i of 0 is treated as a refresh rate of 100.
- R10: busy_o is 1 from the clock edge that accepts a request until the setup ends. A request that arrives while busy is kept, and only the latest such request is applied afterwards.
- R11: The error flag is cleared by the next request that completes, whether it ends in the static path or in the PWM path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_rate_i | input | RATE_W | Source clock rate |
| max_bri_i | input | BRI_W | Largest brightness code |
| refresh_i | input | REF_W | Refresh rate; 0 selects 100 |
| bri_i | input | BRI_W | Requested brightness |
| bri_valid_i | input | 1 | Strobe for bri_i |
| busy_o | output | 1 | Setup sequence in progress |
| psc_code_o | output | 2 | Prescaler code, divider = 4^code |
| period_o | output | RATE_W | Period value in prescaled ticks |
| compare_o | output | RATE_W | Compare point at which the output goes high |
| pwm_en_o | output | 1 | PWM channel enable |
| pin_static_o | output | 1 | 1: pin is a static output; 0: pin routed to the timer |
| pin_level_o | output | 1 | Static pin level |
| err_o | output | 1 | No prescaler could meet the minimum rate |

## Verification
A wrong state or prescaler choice shows up at the ports as a wrong psc_code_o, period_o or compare_o, or as a wrong error flag. It becomes visible in the first idle cycle after the request, which is about two divide lengths (2·(RATE_W+BRI_W)+2 cycles) later. A broken stop/restart order shows up as pwm_en_o being high while busy_o is high, in the very cycle it happens. Faults in the pending slot appear as the wrong final settings once a burst of requests has drained. The sweeps cover every brightness code of several maxima against refresh rates that need each prescaler code, as well as the case where no prescaler fits.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int NUM_PSC     = 4;
  localparam int PSC_W       = $clog2(NUM_PSC);
  localparam int PSC_SHIFT   = 2;
  localparam int DEF_REFRESH = 100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DIV_PER,
    ST_DIV_CMP
  } lps_state_e;
endpackage

// File: rtl/lps_divider.sv
module lps_divider #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, num_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted, diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    ge      = shifted >= {1'b0, den_q};
    diff    = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        num_q <= num_i;
        den_q <= den_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff : shifted;
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  logic [2*W-1:0] recon;
  assign recon = (2*W)'(quo_q) * (2*W)'(den_q) + (2*W)'(rem_q);

  // R4/R5: divider result must reconstruct the dividend exactly
  p_div_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (recon == (2*W)'(num_q)) && (rem_q < {1'b0, den_q}));
  p_div_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/lps_psc_pick.sv
module lps_psc_pick
  import lps_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int MIN_W  = 24
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [MIN_W-1:0]  min_i,
  output logic [PSC_W-1:0]  code_o,
  output logic              ok_o,
  output logic [RATE_W-1:0] scaled_o
);
  localparam int CMP_W = (RATE_W > MIN_W) ? RATE_W : MIN_W;

  logic [RATE_W-1:0]  scaled [NUM_PSC];
  logic [NUM_PSC-1:0] fit;

  for (genvar k = 0; k < NUM_PSC; k++) begin : g_div
    assign scaled[k] = rate_i >> (PSC_SHIFT * k);
    assign fit[k]    = CMP_W'(scaled[k]) >= CMP_W'(min_i);
  end

  // highest fitting divider wins
  always_comb begin
    ok_o     = 1'b0;
    code_o   = '0;
    scaled_o = scaled[0];
    for (int k = 0; k < NUM_PSC; k++) begin
      if (fit[k]) begin
        ok_o     = 1'b1;
        code_o   = PSC_W'(k);
        scaled_o = scaled[k];
      end
    end
  end
endmodule

// File: rtl/led_pwm_setup.sv
module led_pwm_setup
  import lps_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int BRI_W  = 8,
  parameter int REF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] src_rate_i,
  input  logic [BRI_W-1:0]  max_bri_i,
  input  logic [REF_W-1:0]  refresh_i,
  input  logic [BRI_W-1:0]  bri_i,
  input  logic              bri_valid_i,
  output logic              busy_o,
  output logic [PSC_W-1:0]  psc_code_o,
  output logic [RATE_W-1:0] period_o,
  output logic [RATE_W-1:0] compare_o,
  output logic              pwm_en_o,
  output logic              pin_static_o,
  output logic              pin_level_o,
  output logic              err_o
);
  localparam int MIN_W = BRI_W + REF_W;
  localparam int DW    = RATE_W + BRI_W;

  lps_state_e        state_q;
  logic [BRI_W-1:0]  cur_q, pend_q;
  logic              pend_v_q;
  logic [REF_W-1:0]  ref_eff;
  logic [MIN_W-1:0]  min_rate;
  logic [PSC_W-1:0]  pick_code;
  logic              pick_ok;
  logic [RATE_W-1:0] pick_scaled;
  logic              is_static;
  logic              div_start, div_done;
  logic [DW-1:0]     div_num, div_den, div_q;

  assign ref_eff   = (refresh_i == '0) ? REF_W'(DEF_REFRESH) : refresh_i;
  assign min_rate  = MIN_W'(max_bri_i) * MIN_W'(ref_eff);
  assign is_static = (cur_q == '0) || (cur_q == max_bri_i);

  lps_psc_pick #(.RATE_W(RATE_W), .MIN_W(MIN_W)) u_pick (
    .rate_i  (src_rate_i),
    .min_i   (min_rate),
    .code_o  (pick_code),
    .ok_o    (pick_ok),
    .scaled_o(pick_scaled)
  );

  always_comb begin
    if (state_q == ST_SETUP) begin
      div_num = DW'(pick_scaled);
      div_den = DW'(ref_eff);
    end else begin
      div_num = DW'(max_bri_i - cur_q) * DW'(div_q[RATE_W-1:0]);
      div_den = DW'(max_bri_i);
    end
    div_start = ((state_q == ST_SETUP) && !is_static && pick_ok) ||
                ((state_q == ST_DIV_PER) && div_done);
  end

  lps_divider #(.W(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      pend_q       <= '0;
      pend_v_q     <= 1'b0;
      psc_code_o   <= '0;
      period_o     <= '0;
      compare_o    <= '0;
      pwm_en_o     <= 1'b0;
      pin_static_o <= 1'b1;
      pin_level_o  <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && bri_valid_i) begin
        pend_q   <= bri_i;
        pend_v_q <= 1'b1;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (bri_valid_i || pend_v_q) begin
            cur_q    <= bri_valid_i ? bri_i : pend_q;
            pend_v_q <= 1'b0;
            pwm_en_o <= 1'b0;   // stop channel first
            state_q  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (is_static) begin
            pin_static_o <= 1'b1;
            pin_level_o  <= (cur_q != '0);
            err_o        <= 1'b0;
            state_q      <= ST_IDLE;
          end else if (!pick_ok) begin
            pin_static_o <= 1'b0;
            err_o        <= 1'b1;
            state_q      <= ST_IDLE;
          end else begin
            pin_static_o <= 1'b0;
            psc_code_o   <= pick_code;
            state_q      <= ST_DIV_PER;
          end
        end
        ST_DIV_PER: begin
          if (div_done) begin
            period_o <= div_q[RATE_W-1:0];
            state_q  <= ST_DIV_CMP;
          end
        end
        ST_DIV_CMP: begin
          if (div_done) begin
            compare_o <= div_q[RATE_W-1:0];
            pwm_en_o  <= 1'b1;
            err_o     <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  p_stop_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !pwm_en_o);
  p_static_no_pwm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_static_o |-> !pwm_en_o);
  p_err_no_pwm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pwm_en_o);
  p_pwm_on_timer_pin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> !pin_static_o && !err_o);
  p_cmp_in_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o |-> compare_o <= period_o);
  p_psc_fits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o |-> 64'(src_rate_i >> (PSC_SHIFT * psc_code_o)) >= 64'(min_rate));
  p_psc_slowest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en_o && psc_code_o != PSC_W'(NUM_PSC - 1)) |->
      64'(src_rate_i >> (PSC_SHIFT * (psc_code_o + 1))) < 64'(min_rate));
  p_quo_fits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> div_q[DW-1:RATE_W] == '0);
endmodule

// File: tb/led_pwm_setup_tb.sv
module led_pwm_setup_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_rate = 32'd0;
  logic [7:0]  max_bri = 8'd0;
  logic [15:0] refresh = 16'd0;
  logic [7:0]  bri = 8'd0;
  logic        bri_valid = 1'b0;
  logic        busy, pwm_en, pin_static, pin_level, err;
  logic [1:0]  psc_code;
  logic [31:0] period, compare;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  led_pwm_setup u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_rate_i(src_rate), .max_bri_i(max_bri),
    .refresh_i(refresh), .bri_i(bri), .bri_valid_i(bri_valid), .busy_o(busy),
    .psc_code_o(psc_code), .period_o(period), .compare_o(compare),
    .pwm_en_o(pwm_en), .pin_static_o(pin_static), .pin_level_o(pin_level),
    .err_o(err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] b);
    bri       = b;
    bri_valid = 1'b1;
    @(negedge clk);
    bri_valid = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      while (busy) @(negedge clk);
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  // expected results, computed from the requirements
  task automatic expect_run(input longint b, input bit prev_err);
    longint rf, minr, scl, per, cmpv;
    int     k;
    rf   = (refresh == 0) ? 100 : refresh;   // R9
    minr = max_bri * rf;                      // R2
    k    = -1;
    for (int j = 3; j >= 0; j--) begin
      if ((longint'(src_rate) >> (2*j)) >= minr) begin k = j; break; end
    end
    if (b == 0 || b == max_bri) begin
      chk("R6 pin_static", pin_static, 1);
      chk("R6 pin_level", pin_level, (b != 0));
      chk("R6 pwm_en", pwm_en, 0);
      chk("R11 err", err, 0);
    end else if (k < 0) begin
      chk("R3 err", err, 1);
      chk("R3 pwm_en", pwm_en, 0);
      chk("R3 pin_static", pin_static, 0);
    end else begin
      scl  = longint'(src_rate) >> (2*k);
      per  = scl / rf;
      cmpv = (max_bri - b) * per / max_bri;
      chk("R2 psc_code", psc_code, k);
      chk("R4 period", period, per);
      chk("R5 compare", compare, cmpv);
      chk("R7 pwm_en", pwm_en, 1);
      chk("R7 pin_static", pin_static, 0);
      chk("R11 err", err, 0);
    end
    if (prev_err) ;
  endtask

  task automatic run_one(input logic [7:0] b);
    pulse(b);
    chk("R10 busy", busy, 1);
    chk("R8 pwm_en while busy", pwm_en, 0);
    wait_idle();
    expect_run(b, err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint srcs [4] = '{400000, 3000, 50, 2000000};
    int     maxes[3] = '{3, 10, 100};
    int     refs [2] = '{0, 7};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pwm_en", pwm_en, 0);
    chk("R1 pin_static", pin_static, 1);
    chk("R1 pin_level", pin_level, 0);
    chk("R1 err", err, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (srcs[s]) foreach (maxes[m]) foreach (refs[r]) begin
      src_rate = 32'(srcs[s]);
      max_bri  = 8'(maxes[m]);
      refresh  = 16'(refs[r]);
      for (int b = 0; b <= maxes[m]; b++) run_one(8'(b));
    end

    // R3 then R11: failing request, then a static one clears the error
    src_rate = 32'd50; max_bri = 8'd100; refresh = 16'd0;
    run_one(8'd50);
    chk("R3 err set", err, 1);
    run_one(8'd0);
    chk("R11 err cleared", err, 0);

    // R10: burst while busy, only the latest applies
    src_rate = 32'd400000; max_bri = 8'd100; refresh = 16'd7;
    pulse(8'd50);
    pulse(8'd20);
    chk("R10 busy during burst", busy, 1);
    pulse(8'd80);
    wait_idle();
    expect_run(80, 0);
    chk("R10 latest compare", compare, (100 - 80) * ((400000 >> 6) / 7) / 100);

    // R9: refresh 0 acts as 100
    src_rate = 32'd2000000; max_bri = 8'd100; refresh = 16'd0;
    run_one(8'd25);
    chk("R9 period", period, (2000000 >> 6) / 100);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule